// File: doc/BRIEF.md
# Linear Slack Frame Speed Governor

This block picks a clock speed level for each frame decode in a video pipeline that keeps a frame buffer between decoder and display. It keeps a running slack value in timer ticks. Each finished frame credits the slack with one display interval and debits it with that frame's measured decode time. The block sums the most recent slack samples and maps their mean onto a normalized speed through a falling straight line. Zero excess slack gives full speed. An excess of one buffer depth's worth of display intervals gives the slowest speed. The mapped speed is rounded up to the nearest entry of an ascending table of discrete levels.

The decoder pulses `start_i` when it begins a frame and `done_i` when it finishes. A free-running tick counter comes in on `tick_i`. On each start the block registers the level index to use for that frame and raises `valid_o` for one cycle. Speeds are unsigned fixed point, with 1.0 encoded as 32768. The defaults are a display interval of 1000 ticks, a buffer depth of 5, an averaging window of 3, a speed range of 14254 to 32768 and 14 levels.

Top module: `dvs_slack_gov`

## Requirements
- R1: Every slack sample and the slack register reset to PERIOD. After reset `level_o` is LVL_N-1 and `valid_o` is 0, and the first decision after reset selects level LVL_N-1.
- R2: A decode's duration is (tick_i when done_i is sampled) minus (tick_i when start_i was sampled), taken modulo 2^TICK_W, so the difference survives a counter wrap. On `done_i` the slack becomes slack + PERIOD - duration.
- R3: The slack update saturates. A result below 0 becomes 0, and a result above 2^SLK_W-1 becomes 2^SLK_W-1.
- R4: Each `done_i` pushes the new slack into a window of the WIN most recent samples, and the oldest sample drops out. A decision uses the sum S of the window as it stands before the start edge.
- R5: The speed is computed from the excess E = S - WIN*PERIOD, with GAIN = floor((UMAX-UMIN)*2^16 / (WIN*BUF_D*PERIOD)). If S <= WIN*PERIOD the speed is UMAX. If E >= WIN*BUF_D*PERIOD the speed is UMIN. Otherwise the speed is UMAX - floor(E*GAIN/2^16), limited below to UMIN.
- R6: The level table has LVL_N ascending entries, and by default entry k is UMIN + floor((UMAX-UMIN)*k/(LVL_N-1)). The chosen index is the lowest k whose entry is greater than or equal to the speed.
- R7: `valid_o` is high exactly in the cycle after a sampled `start_i`, and `level_o` changes only in that cycle. A `done_i` does not change `level_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame decode begins (one-cycle strobe) |
| done_i | input | 1 | Frame decode finished (one-cycle strobe) |
| tick_i | input | TICK_W | Free-running timer value |
| level_o | output | LVL_W | Selected speed level index |
| valid_o | output | 1 | One-cycle pulse when a new level is presented |

## Verification
The assertions assume that each `done_i` closes a decode opened by an earlier `start_i`, that the two strobes never arrive in the same cycle, and that the level table ascends and ends at UMAX. The bench drives each frame as a start pulse and then, two cycles later, a done pulse. It sets `tick_i` directly to a chosen base and to base plus the duration, which makes durations exact and includes counter wraps. It sweeps durations across the whole linear region, drives the slack into both saturation limits, and runs a long mixed pattern.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  localparam int SPD_W   = 16;
  localparam int LVL_MAX = 32;
  localparam int FRAC    = 16;

  // Evenly spaced ascending levels, entry k at bits [k*SPD_W +: SPD_W]
  function automatic logic [LVL_MAX*SPD_W-1:0] level_ramp(int n, int umin, int umax);
    logic [LVL_MAX*SPD_W-1:0] r;
    int v;
    r = '0;
    for (int k = 0; k < LVL_MAX; k++) begin
      if (k < n) begin
        v = umin + ((umax - umin) * k) / (n - 1);
        r[k*SPD_W +: SPD_W] = SPD_W'(v);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/dvs_slack_acc.sv
module dvs_slack_acc #(
  parameter int TICK_W = 16,
  parameter int SLK_W  = 20,
  parameter int PERIOD = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [SLK_W-1:0]  slack_nxt_o
);
  logic [TICK_W-1:0] t0_q;
  logic [TICK_W-1:0] dur;
  logic [SLK_W-1:0]  slack_q;
  logic [SLK_W:0]    grown, dur_w, diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t0_q <= '0;
    else if (start_i) t0_q <= tick_i;
  end

  assign dur   = tick_i - t0_q;  // modulo wrap
  assign grown = {1'b0, slack_q} + (SLK_W+1)'(PERIOD);
  assign dur_w = (SLK_W+1)'(dur);
  assign diff  = grown - dur_w;

  always_comb begin
    if (grown <= dur_w)  slack_nxt_o = '0;
    else if (diff[SLK_W]) slack_nxt_o = '1;
    else                 slack_nxt_o = diff[SLK_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slack_q <= SLK_W'(PERIOD);
    else if (done_i) slack_q <= slack_nxt_o;
  end

  assert_slack_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(slack_q));
endmodule

// File: rtl/dvs_slack_avg.sv
module dvs_slack_avg #(
  parameter int SLK_W  = 20,
  parameter int WIN    = 3,
  parameter int PERIOD = 1000,
  localparam int SUM_W = SLK_W + $clog2(WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [SLK_W-1:0] sample_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [WIN-1:0][SLK_W-1:0] tap_q;

  generate
    for (genvar g = 0; g < WIN; g++) begin : g_tap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tap_q[g] <= SLK_W'(PERIOD);
        else if (push_i) tap_q[g] <= (g == 0) ? sample_i : tap_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < WIN; k++) sum_o = sum_o + SUM_W'(tap_q[k]);
  end

  assert_window_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(sum_o));
endmodule

// File: rtl/dvs_speed_map.sv
module dvs_speed_map #(
  parameter int SUM_W  = 22,
  parameter int SPD_W  = 16,
  parameter int WIN    = 3,
  parameter int BUF_D  = 5,
  parameter int PERIOD = 1000,
  parameter int UMAX   = 32768,
  parameter int UMIN   = 14254,
  parameter int FRAC   = 16
) (
  input  logic [SUM_W-1:0] sum_i,
  output logic [SPD_W-1:0] speed_o
);
  localparam longint BASE = longint'(WIN) * PERIOD;
  localparam longint SPAN = longint'(WIN) * BUF_D * PERIOD;
  localparam longint RNG  = longint'(UMAX - UMIN);
  localparam longint GAIN = (RNG << FRAC) / SPAN;

  logic [63:0] sum_w, excess, prod, drop;

  assign sum_w  = 64'(sum_i);
  assign excess = sum_w - 64'(BASE);
  assign prod   = excess * 64'(GAIN);
  assign drop   = prod >> FRAC;

  always_comb begin
    if (sum_w <= 64'(BASE))        speed_o = SPD_W'(UMAX);
    else if (excess >= 64'(SPAN))  speed_o = SPD_W'(UMIN);
    else if (drop >= 64'(RNG))     speed_o = SPD_W'(UMIN);
    else                           speed_o = SPD_W'(64'(UMAX) - drop);
  end
endmodule

// File: rtl/dvs_level_quant.sv
module dvs_level_quant #(
  parameter int SPD_W = 16,
  parameter int LVL_N = 14,
  parameter logic [LVL_N*SPD_W-1:0] LEVELS = '1,
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic [SPD_W-1:0] speed_i,
  output logic [LVL_W-1:0] sel_o
);
  logic [LVL_N-1:0] ge;

  generate
    for (genvar g = 0; g < LVL_N; g++) begin : g_cmp
      assign ge[g] = LEVELS[g*SPD_W +: SPD_W] >= speed_i;
    end
  endgenerate

  // lowest qualifying entry wins; top entry is the fallback
  always_comb begin
    sel_o = LVL_W'(LVL_N - 1);
    for (int k = LVL_N - 1; k >= 0; k--) begin
      if (ge[k]) sel_o = LVL_W'(k);
    end
  end
endmodule

// File: rtl/dvs_slack_gov.sv
module dvs_slack_gov #(
  parameter int TICK_W = 16,
  parameter int SLK_W  = 20,
  parameter int PERIOD = 1000,
  parameter int BUF_D  = 5,
  parameter int WIN    = 3,
  parameter int SPD_W  = dvs_pkg::SPD_W,
  parameter int UMAX   = 32768,
  parameter int UMIN   = 14254,
  parameter int LVL_N  = 14,
  parameter logic [LVL_N*SPD_W-1:0] LEVELS =
    (LVL_N*SPD_W)'(dvs_pkg::level_ramp(LVL_N, UMIN, UMAX)),
  localparam int LVL_W = $clog2(LVL_N),
  localparam int SUM_W = SLK_W + $clog2(WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [LVL_W-1:0]  level_o,
  output logic              valid_o
);
  logic [SLK_W-1:0] slack_nxt;
  logic [SUM_W-1:0] sum;
  logic [SPD_W-1:0] speed;
  logic [LVL_W-1:0] sel;

  dvs_slack_acc #(.TICK_W(TICK_W), .SLK_W(SLK_W), .PERIOD(PERIOD)) u_acc (
    .clk_i, .rst_ni, .start_i, .done_i, .tick_i, .slack_nxt_o(slack_nxt));

  dvs_slack_avg #(.SLK_W(SLK_W), .WIN(WIN), .PERIOD(PERIOD)) u_avg (
    .clk_i, .rst_ni, .push_i(done_i), .sample_i(slack_nxt), .sum_o(sum));

  dvs_speed_map #(.SUM_W(SUM_W), .SPD_W(SPD_W), .WIN(WIN), .BUF_D(BUF_D),
    .PERIOD(PERIOD), .UMAX(UMAX), .UMIN(UMIN), .FRAC(dvs_pkg::FRAC)) u_map (
    .sum_i(sum), .speed_o(speed));

  dvs_level_quant #(.SPD_W(SPD_W), .LVL_N(LVL_N), .LEVELS(LEVELS)) u_quant (
    .speed_i(speed), .sel_o(sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= LVL_W'(LVL_N - 1);
      valid_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) level_o <= sel;
    end
  end

  assert_valid_follows_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  assert_valid_needs_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i));
  assert_level_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(level_o));
  assert_speed_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed >= SPD_W'(UMIN)) && (speed <= SPD_W'(UMAX)));
  assert_level_covers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LEVELS[sel*SPD_W +: SPD_W] >= speed);
  assert_level_lowest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel != '0) |-> (LEVELS[(sel-1'b1)*SPD_W +: SPD_W] < speed));
endmodule

// File: tb/dvs_slack_gov_tb.sv
module dvs_slack_gov_tb;
  localparam int CLK_P  = 10;
  localparam int PERIOD = 1000;
  localparam int BUF_D  = 5;
  localparam int WIN    = 3;
  localparam int UMAX   = 32768;
  localparam int UMIN   = 14254;
  localparam int LVL_N  = 14;
  localparam longint SMAX = (longint'(1) << 20) - 1;

  logic        clk = 0, rst_n = 0, start = 0, done = 0;
  logic [15:0] tick = '0;
  logic [3:0]  level;
  logic        valid;

  int n_chk = 0, n_bad = 0;
  longint slack;
  longint win_s [WIN];
  int base = 0;

  always #(CLK_P/2) clk = ~clk;

  dvs_slack_gov u_dut (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_i(done),
    .tick_i(tick), .level_o(level), .valid_o(valid));

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lvl_val(int k);
    return UMIN + (longint'(UMAX - UMIN) * k) / (LVL_N - 1);
  endfunction

  // R5 / R6 model from the window sum
  function automatic int model_level();
    longint s = 0, e, gain, spd;
    for (int k = 0; k < WIN; k++) s += win_s[k];
    gain = (longint'(UMAX - UMIN) << 16) / (WIN * BUF_D * PERIOD);
    if (s <= WIN * PERIOD) spd = UMAX;
    else begin
      e = s - WIN * PERIOD;
      if (e >= WIN * BUF_D * PERIOD) spd = UMIN;
      else begin
        spd = UMAX - ((e * gain) >> 16);
        if (spd < UMIN) spd = UMIN;
      end
    end
    for (int k = 0; k < LVL_N; k++) if (lvl_val(k) >= spd) return k;
    return LVL_N - 1;
  endfunction

  task automatic frame(int dur);
    int exp_l = model_level();
    @(negedge clk); tick = 16'(base); start = 1;
    @(negedge clk); start = 0;
    check("R7 valid after start", valid, 1);
    check("R5 R6 level", level, exp_l);
    @(negedge clk);
    check("R7 valid pulse width", valid, 0);
    tick = 16'(base + dur); done = 1;
    @(negedge clk); done = 0;
    check("R7 level held over done", level, exp_l);
    // R2 R3 R4 model update
    slack = slack + PERIOD - (dur % 65536);
    if (slack < 0) slack = 0;
    if (slack > SMAX) slack = SMAX;
    for (int k = WIN - 1; k > 0; k--) win_s[k] = win_s[k-1];
    win_s[0] = slack;
    base = (base + 7919) % 65536;
  endtask

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    slack = PERIOD;
    for (int k = 0; k < WIN; k++) win_s[k] = PERIOD;
    repeat (3) @(negedge clk);
    check("R1 reset level", level, LVL_N - 1);
    check("R1 reset valid", valid, 0);
    rst_n = 1;
    @(negedge clk);
    frame(500);  // R1 first decision full speed
    // R5 sweep through the linear region
    for (int d = 0; d <= 3000; d += 50) frame(d);
    // R8-style wrap of the tick counter, R2
    base = 65400; frame(1200);
    base = 65530; frame(300);
    // R3 upper saturation, slowest level
    for (int k = 0; k < 1100; k++) frame(0);
    // R3 drain from the ceiling, then floor at zero
    for (int k = 0; k < 25; k++) frame(65000);
    frame(900);
    frame(0);
    // R4 mixed pattern
    for (int k = 0; k < 200; k++) frame((k * 733) % 2600);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule